// File: doc/BRIEF.md
# Memory-Backed Tapped Delay Line

This block delays a stream of `W`-bit samples and presents `N` delayed copies at once. The copies are spaced `M` shift steps apart, so the deepest one lags the input by `M*N` steps. The stored samples are kept in one array of `M` words, each `W*N` bits wide, and not in a chain of flip-flops. A ring pointer selects the word for the current step. On the rising clock edge that accepts a shift, the word at the pointer is read into the tap register. On the falling edge of the same cycle, that word is rewritten: every tap field moves up one slot and the new input goes into the lowest slot. One complete step therefore fits in a single clock period.

The taps come out as one word, and the same word feeds the write-back path. A longer line is built by chaining instances: the highest tap field of one instance drives `din` of the next, and every instance shares the same shift enable. A synchronous reset returns the pointer to word zero. It does not clear the stored data. The taps carry meaningful values only after more than `M*N` shifts have followed reset.

Top module: `ram_tap_delay`

## Requirements
- R1: The parameters `W`, `M` and `N` set the sample width, the tap spacing and the tap count. Elaboration fails if `W*N` exceeds 36 or if `W*M*N` exceeds 4608. The limit configurations (36-bit words, and 4608 bits of storage) work like any other configuration.
- R2: `taps` holds `N` fields of `W` bits each, with field k at bits `[k*W +: W]`. Once more than `M*N` shifts have been accepted since reset, field k after any accepted shift equals the `din` value accepted (k+1)*M shifts earlier.
- R3: Each rising edge with `shift_en` high and `rst` low completes one full shift, meaning the read of the stored word and the write-back of the moved word. `taps` shows the result immediately after that edge.
- R4: With `M` = 1 every shift reads and rewrites the same word in one cycle. Tap field 0 then equals the `din` of the preceding accepted shift.
- R5: With `N` = 1 the single field is the input delayed by `M` accepted shifts, and the whole word carries the sample.
- R6: While `shift_en` is low, `taps`, the pointer and the stored words stay unchanged, and `din` is ignored. Shifts that follow continue the sequence as if the idle cycles had not occurred.
- R7: A rising edge with `rst` high sets the pointer to word zero and performs no shift, even when `shift_en` is high, so `taps` holds its value.
- R8: In a chain where the top field of instance A drives `din` of instance B, field k of B equals the input of A delayed by `N_A*M_A + 1 + (k+1)*M_B` accepted shifts. The `+1` comes from A's registered tap output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge reads, falling edge writes |
| rst | input | 1 | Synchronous reset of the ring pointer, active high |
| shift_en | input | 1 | Accepts one shift step at the next rising edge |
| din | input | W | Sample that enters tap slot 0 |
| taps | output | W*N | All tap fields, field k at bits [k*W +: W] |

## Verification
The read of a word and the rewrite of that same word fall in the same clock cycle. With `M` = 1 they also hit the same address on every step. An instance with a single word and 36-bit words is shifted on every cycle. Tap field 0 must then show the previous sample on each edge, which is only possible if the falling-edge write lands after the rising-edge read and before the next one. Reset coinciding with a high shift enable is also applied, and it is judged by the taps holding their value.

// File: rtl/tapdl_pkg.sv
`timescale 1ns/1ps
package tapdl_pkg;
   // Widest word one storage array offers.
   localparam int unsigned WORD_LIMIT  = 36;
   // Total bits one storage array holds.
   localparam int unsigned STORE_LIMIT = 4608;

   // Pointer width for a ring of the given depth (at least one bit).
   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/tapdl_ptr.sv
`timescale 1ns/1ps
module tapdl_ptr #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = tapdl_pkg::addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (rst)
         ptr <= '0;
      else if (step)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R3: each accepted shift moves the ring one word on, wrapping at the end
   a_r3_ptr_step : assert property (@(posedge clk) disable iff (rst)
      step |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

   // R6: no shift, no pointer movement
   a_r6_ptr_hold : assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(ptr));

   // R2: pointer never leaves the ring
   a_r2_ptr_range : assert property (@(posedge clk) disable iff (rst)
      ptr <= LAST);
endmodule

// File: rtl/tapdl_mem.sv
`timescale 1ns/1ps
module tapdl_mem #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 32,
   parameter int unsigned AW    = tapdl_pkg::addr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   output logic [WIDTH-1:0] rd_word,
   input  logic [WIDTH-1:0] wr_word
);
   logic [WIDTH-1:0] store [DEPTH];
   logic [AW-1:0]    addr_q;
   logic             wr_pend;

   // Rising edge: fetch the word and remember where it came from.
   always_ff @(posedge clk) begin
      wr_pend <= rd_en;
      if (rd_en) begin
         rd_word <= store[addr];
         addr_q  <= addr;
      end
   end

   // Falling edge of the same cycle: put the moved word back.
   always_ff @(negedge clk) begin
      if (wr_pend)
         store[addr_q] <= wr_word;
   end
endmodule

// File: rtl/ram_tap_delay.sv
`timescale 1ns/1ps
module ram_tap_delay #(
   parameter int unsigned W = 8,
   parameter int unsigned M = 16,
   parameter int unsigned N = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic [W-1:0]   din,
   output logic [W*N-1:0] taps
);
   localparam int unsigned AW     = tapdl_pkg::addr_bits(M);
   localparam int unsigned WORD_W = W * N;
   localparam int unsigned BITS   = W * M * N;

   // R1: parameter limits enforced while elaborating
   generate
      if (W == 0 || M == 0 || N == 0) begin : g_bad_zero
         $error("ram_tap_delay: W, M and N must all be nonzero");
      end
      if (WORD_W > tapdl_pkg::WORD_LIMIT) begin : g_bad_width
         $error("ram_tap_delay: word of %0d bits exceeds limit", WORD_W);
      end
      if (BITS > tapdl_pkg::STORE_LIMIT) begin : g_bad_store
         $error("ram_tap_delay: %0d storage bits exceed limit", BITS);
      end
   endgenerate

   logic              step;
   logic [AW-1:0]     ptr;
   logic [W-1:0]      din_q;
   logic [WORD_W-1:0] wr_word;

   assign step = shift_en & ~rst;

   always_ff @(posedge clk) begin
      if (step)
         din_q <= din;
   end

   // Pointer variant: one word needs no counter.
   generate
      if (M == 1) begin : g_one_slot
         assign ptr = '0;

         // R4: read and rewrite of the single word in one cycle
         a_r4_single_slot : assert property (@(posedge clk) disable iff (rst)
            $past(step) && $past(step, 2) |-> taps[W-1:0] == $past(din, 2));
      end else begin : g_ring
         tapdl_ptr #(.DEPTH(M), .AW(AW)) u_ptr (
            .clk  (clk),
            .rst  (rst),
            .step (step),
            .ptr  (ptr)
         );
      end
   endgenerate

   // Write-back packing variant: one tap keeps only the new sample.
   generate
      if (N == 1) begin : g_single_tap
         assign wr_word = din_q;
      end else begin : g_multi_tap
         assign wr_word = {taps[(N-1)*W-1:0], din_q};
      end
   endgenerate

   tapdl_mem #(.DEPTH(M), .WIDTH(WORD_W), .AW(AW)) u_mem (
      .clk     (clk),
      .rd_en   (step),
      .addr    (ptr),
      .rd_word (taps),
      .wr_word (wr_word)
   );

   // R6: tap word frozen on idle cycles
   a_r6_taps_hold : assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(taps));
endmodule

// File: tb/ram_tap_delay_tb.sv
`timescale 1ns/1ps
module ram_tap_delay_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        shift_en = 1'b0;
   logic [35:0] din = '0;

   logic [31:0] dut_taps;
   logic [35:0] m1_taps;
   logic [35:0] n1_taps;
   logic [11:0] ca_taps;
   logic [17:0] cb_taps;

   int unsigned vectors = 0;
   int unsigned fails   = 0;
   int          j       = 0;
   logic [35:0] hist [0:2047];
   logic [35:0] lfsr = 36'h5A5A_1234_5;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ram_tap_delay #(.W(8), .M(16), .N(4)) u_dut (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din[7:0]), .taps(dut_taps));
   ram_tap_delay #(.W(9), .M(1), .N(4)) u_m1 (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din[8:0]), .taps(m1_taps));
   ram_tap_delay #(.W(36), .M(128), .N(1)) u_n1 (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .taps(n1_taps));
   ram_tap_delay #(.W(6), .M(3), .N(2)) u_ca (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din[5:0]), .taps(ca_taps));
   ram_tap_delay #(.W(6), .M(2), .N(3)) u_cb (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(ca_taps[11:6]), .taps(cb_taps));

   function automatic logic [35:0] next_val(input logic [35:0] s);
      return {s[34:0], s[35] ^ s[24]} ^ 36'h0_9E37_79B1;
   endfunction

   task automatic check_eq(input string req, input string what,
                           input logic [35:0] got, input logic [35:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Compare every field of one instance against the input history.
   task automatic check_taps(input string req, input string name, input logic [35:0] got,
                             input int w, input int m, input int n, input int lead);
      logic [35:0] mask;
      mask = (36'd1 << w) - 36'd1;
      if (j <= lead + m * n) return;
      for (int k = 0; k < n; k++) begin
         int idx;
         idx = j - lead - (k + 1) * m;
         check_eq(req, $sformatf("%s field %0d after shift %0d", name, k, j),
                  (got >> (k * w)) & mask, hist[idx] & mask);
      end
   endtask

   task automatic check_all();
      check_taps("R2", "u_dut", {4'h0, dut_taps}, 8, 16, 4, 0);
      check_taps("R4", "u_m1", m1_taps, 9, 1, 4, 0);
      check_taps("R5", "u_n1", n1_taps, 36, 128, 1, 0);
      check_taps("R1", "u_n1 limit", n1_taps, 36, 128, 1, 0);
      check_taps("R1", "u_m1 limit", m1_taps, 9, 1, 4, 0);
      check_taps("R8", "u_cb", {18'h0, cb_taps}, 6, 2, 3, 7);
   endtask

   // One clock: drive at the falling edge, sample 1 ns after the rising edge.
   task automatic step(input logic en);
      @(negedge clk);
      shift_en = en;
      lfsr = next_val(lfsr);
      if (en) begin
         j++;
         hist[j] = lfsr;
      end
      din = lfsr;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] snap;
      rst = 1'b1;
      step(1'b1);
      snap = dut_taps;
      for (int i = 0; i < 4; i++) begin
         step(1'b1);
         check_eq("R7", "taps held while reset with shift_en high", {4'h0, dut_taps}, {4'h0, snap});
      end
      j = 0;
      @(negedge clk);
      rst = 1'b0;
      shift_en = 1'b0;
   endtask

   task automatic t_stream(input int count);
      for (int i = 0; i < count; i++) begin
         step(1'b1);
         check_all();   // R3: result visible right after the accepting edge
      end
   endtask

   task automatic t_idle(input int count);
      logic [31:0] s_dut;
      logic [35:0] s_m1, s_n1;
      logic [17:0] s_cb;
      s_dut = dut_taps; s_m1 = m1_taps; s_n1 = n1_taps; s_cb = cb_taps;
      for (int i = 0; i < count; i++) begin
         step(1'b0);
         check_eq("R6", "u_dut idle hold", {4'h0, dut_taps}, {4'h0, s_dut});
         check_eq("R6", "u_m1 idle hold", m1_taps, s_m1);
         check_eq("R6", "u_n1 idle hold", n1_taps, s_n1);
         check_eq("R6", "u_cb idle hold", {18'h0, cb_taps}, {18'h0, s_cb});
      end
   endtask

   task automatic t_gappy(input int count);
      for (int i = 0; i < count; i++) begin
         step((i % 3) != 1);
         if ((i % 3) != 1) check_all();   // R6: sequence continues across gaps
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_stream(300);
      t_idle(7);
      t_stream(40);
      t_gappy(240);
      t_idle(3);
      t_stream(150);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end
endmodule